// File: doc/BRIEF.md
# Caption Line Waveform Inserter

This block produces the digital waveform for caption or extended-data bytes on one chosen video line in every field. The surrounding video timing supplies a line-start strobe, the current line number and the field parity. When the line number equals a 5-bit programmable target, the block picks one of two 16-bit payloads, one for odd fields and one for even fields. After a fixed lead-in it emits a sequence of 26 bit periods: a seven-cycle clock run-in, a three-bit framing pattern, and then the two payload bytes. The output is an 8-bit level code that the luminance path adds in. A valid strobe marks the cycles that carry the waveform.

Bit timing comes from a fractional accumulator clocked at 27 MHz. It gives exactly 32 bit periods per line length, for both 60 Hz timing (1716 clocks per line) and 50 Hz timing (1728 clocks per line). The host supplies the parity bits inside the payload bytes.

Top module: `cc_line_inserter`

## Requirements
- R1: After reset, `cc_valid` is 0 and `cc_level` is the zero-level code (16).
- R2: No waveform starts unless `line_start` is high in a cycle where `line_num` equals the zero-extended `target_line`.
- R3: `cc_valid` first reads high LEAD_CLKS (240) cycles after the clock edge that sampled a matching `line_start`. It stays high for ceil(26·L/32) cycles: 1395 for L=1716 and 1404 for L=1728.
- R4: Counting waveform cycles c from 0, cycle c belongs to bit floor(32·c/L). L is 1728 when `mode_50hz` was 1 at line start, and 1716 otherwise.
- R5: Bits 0 to 6 form the run-in. Within each bit, the quarter q = floor(4·((32·c) mod L)/L) selects the level: mid-level code 71 for q=0, high code 126 for q=1, 71 for q=2, and zero code 16 for q=3.
- R6: Bits 7 and 8 are framing zeros (level 16) and bit 9 is a framing one (level 126).
- R7: Bits 10 to 17 carry payload bits [7:0] and bits 18 to 25 carry payload bits [15:8], least significant bit first. A 1 gives level 126 and a 0 gives level 16 for the whole bit.
- R8: When `field_odd` is 1 at line start, the odd payload is sent; otherwise the even payload is sent.
- R9: The payload and `mode_50hz` are captured at line start. Changing them while a waveform is in progress does not alter that waveform.
- R10: Whenever `cc_valid` is 0, `cc_level` is 16.
- R11: A matching `line_start` during lead-in or waveform is ignored and does not restart or shift the waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_start | input | 1 | One-cycle strobe at the start of each line |
| line_num | input | 10 | Current line number within the field |
| field_odd | input | 1 | 1 in odd fields, 0 in even fields |
| mode_50hz | input | 1 | 1 selects 1728-clock lines, 0 selects 1716-clock lines |
| target_line | input | 5 | Line on which the caption is inserted |
| odd_payload | input | 16 | Two bytes for odd fields, first byte in [7:0] |
| even_payload | input | 16 | Two bytes for even fields, first byte in [7:0] |
| cc_level | output | 8 | Level code to add to luminance |
| cc_valid | output | 1 | High while the waveform is being emitted |

## Verification
All outputs are decoded from registers, so a matching `line_start` sampled at edge E makes the first waveform cycle visible just after edge E+240. Waveform cycle c is then visible after edge E+240+c. The bench drives inputs and samples outputs on the falling edge. It captures one full line of 1716 falling-edge samples, indexed by how many rising edges have passed since E. Each sample is compared against a value computed directly from the bit and quarter formulas of R4 and R5. Mid-line payload and mode changes, and a repeated `line_start`, are applied at fixed indices inside that capture window.

// File: rtl/cc_pkg.sv
// Shared types and constants for the caption line waveform inserter.
// Assumes the waveform layout: run-in bits, then three framing bits, then the payload.
package cc_pkg;
    // Sequencer states of the bit timer
    typedef enum logic [1:0] {
        CC_IDLE = 2'd0,
        CC_LEAD = 2'd1,
        CC_WAVE = 2'd2
    } cc_state_t;

    // Framing pattern, index 0 sent first: 0, 0, 1
    localparam int        CC_FRAME_BITS = 3;
    localparam logic [2:0] CC_FRAME_PAT = 3'b100;
endpackage

// File: rtl/cc_field_select.sv
// Detects the target line and latches the payload for the current field.
// Assumes line_start is a one-cycle strobe. A start is refused while the timer is busy.
module cc_field_select #(
    parameter int LINE_W = 10,
    parameter int TGT_W  = 5,
    parameter int PAY_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic [LINE_W-1:0] line_num,
    input  logic [TGT_W-1:0]  target_line,
    input  logic              field_odd,
    input  logic [PAY_W-1:0]  odd_payload,
    input  logic [PAY_W-1:0]  even_payload,
    input  logic              busy,
    output logic              start,
    output logic [PAY_W-1:0]  payload_q
);
    logic line_hit;

    // Compare the running line number with the programmed target
    always_comb begin
        line_hit = (line_num == LINE_W'(target_line));
        start    = line_start && line_hit && !busy;
    end

    // Capture the field's byte pair once, at the start of the target line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            payload_q <= '0;
        end else if (start) begin
            payload_q <= field_odd ? odd_payload : even_payload;
        end
    end
endmodule

// File: rtl/cc_bit_timer.sv
// Sequences the lead-in and the bit periods of the caption waveform.
// A fractional accumulator adds RATE_MUL every clock and wraps at the line length.
// This yields exactly RATE_MUL bits per line length. The line length is latched at start.
module cc_bit_timer
    import cc_pkg::*;
#(
    parameter int LEAD_CLKS = 240,
    parameter int CLKS_60   = 1716,
    parameter int CLKS_50   = 1728,
    parameter int RATE_MUL  = 32,
    parameter int NBITS     = 26,
    localparam int LMAX     = (CLKS_50 > CLKS_60) ? CLKS_50 : CLKS_60,
    localparam int ACC_W    = $clog2(LMAX + RATE_MUL + 1),
    localparam int LEAD_W   = $clog2(LEAD_CLKS + 1),
    localparam int BIT_W    = $clog2(NBITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             mode_50hz,
    output logic             busy,
    output logic             in_wave,
    output logic [BIT_W-1:0] bit_idx,
    output logic [1:0]       quarter
);
    localparam int Q_W = ACC_W + 2;

    cc_state_t         state;
    logic [LEAD_W-1:0] lead_cnt;
    logic [ACC_W-1:0]  acc;
    logic [ACC_W-1:0]  len_q;
    logic [ACC_W-1:0]  acc_sum;
    logic              wrap;
    logic              last_bit;
    logic [Q_W-1:0]    acc4, len1, len2, len3;

    // Next accumulator value and bit-boundary detection
    always_comb begin
        acc_sum  = acc + ACC_W'(RATE_MUL);
        wrap     = (acc_sum >= len_q);
        last_bit = (bit_idx == BIT_W'(NBITS - 1));
    end

    // Position within the current bit in quarters of a bit period
    always_comb begin
        acc4 = {acc, 2'b00};
        len1 = Q_W'(len_q);
        len2 = len1 << 1;
        len3 = len1 + len2;
        if (acc4 >= len3)      quarter = 2'd3;
        else if (acc4 >= len2) quarter = 2'd2;
        else if (acc4 >= len1) quarter = 2'd1;
        else                   quarter = 2'd0;
    end

    // State, lead-in counter and fractional bit accumulator
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= CC_IDLE;
            lead_cnt <= '0;
            acc      <= '0;
            bit_idx  <= '0;
            len_q    <= ACC_W'(CLKS_60);
        end else begin
            case (state)
                CC_IDLE: begin
                    if (start) begin
                        state    <= CC_LEAD;
                        lead_cnt <= '0;
                        len_q    <= mode_50hz ? ACC_W'(CLKS_50) : ACC_W'(CLKS_60);
                    end
                end
                CC_LEAD: begin
                    if (lead_cnt == LEAD_W'(LEAD_CLKS - 1)) begin
                        state   <= CC_WAVE;
                        acc     <= '0;
                        bit_idx <= '0;
                    end else begin
                        lead_cnt <= lead_cnt + 1'b1;
                    end
                end
                CC_WAVE: begin
                    if (wrap) begin
                        acc <= acc_sum - len_q;
                        if (last_bit) state   <= CC_IDLE;
                        else          bit_idx <= bit_idx + 1'b1;
                    end else begin
                        acc <= acc_sum;
                    end
                end
                default: state <= CC_IDLE;
            endcase
        end
    end

    // Status toward the selector and the level shaper
    always_comb begin
        busy    = (state != CC_IDLE);
        in_wave = (state == CC_WAVE);
    end
endmodule

// File: rtl/cc_level_shaper.sv
// Maps the current bit index and quarter phase to a level code.
// The run-in is a four-step sine approximation, framing and data use two levels.
// Purely decoded from timer and payload registers, so it adds no latency.
module cc_level_shaper
    import cc_pkg::*;
#(
    parameter int LVL_W      = 8,
    parameter int LVL_ZERO   = 16,
    parameter int LVL_HIGH   = 126,
    parameter int RUNIN_BITS = 7,
    parameter int PAY_W      = 16,
    parameter int BIT_W      = 5,
    localparam int DIDX_W    = $clog2(PAY_W)
) (
    input  logic             in_wave,
    input  logic [BIT_W-1:0] bit_idx,
    input  logic [1:0]       quarter,
    input  logic [PAY_W-1:0] payload,
    output logic [LVL_W-1:0] level,
    output logic             valid
);
    localparam logic [LVL_W-1:0] L_ZERO = LVL_W'(LVL_ZERO);
    localparam logic [LVL_W-1:0] L_HIGH = LVL_W'(LVL_HIGH);
    localparam logic [LVL_W-1:0] L_MID  = LVL_W'((LVL_ZERO + LVL_HIGH) / 2);

    logic [BIT_W-1:0] frame_rel;
    logic [BIT_W-1:0] data_rel;
    logic             one_bit;

    // Offsets of the bit index into the framing and data sections
    always_comb begin
        frame_rel = bit_idx - BIT_W'(RUNIN_BITS);
        data_rel  = bit_idx - BIT_W'(RUNIN_BITS + CC_FRAME_BITS);
        one_bit   = payload[data_rel[DIDX_W-1:0]];
    end

    // Select the level for this cycle
    always_comb begin
        valid = in_wave;
        level = L_ZERO;
        if (in_wave) begin
            if (bit_idx < BIT_W'(RUNIN_BITS)) begin
                case (quarter)
                    2'd0:    level = L_MID;
                    2'd1:    level = L_HIGH;
                    2'd2:    level = L_MID;
                    default: level = L_ZERO;
                endcase
            end else if (frame_rel < BIT_W'(CC_FRAME_BITS)) begin
                level = CC_FRAME_PAT[frame_rel[1:0]] ? L_HIGH : L_ZERO;
            end else begin
                level = one_bit ? L_HIGH : L_ZERO;
            end
        end
    end
endmodule

// File: rtl/cc_line_inserter.sv
// Top of the caption line waveform inserter.
// Matches the target line, latches the field payload and times 26 bits at 32 per line.
// Drives the level code and its valid strobe. Assumes a 27 MHz clock and one line_start per line.
module cc_line_inserter #(
    parameter int LINE_W     = 10,
    parameter int TGT_W      = 5,
    parameter int BYTE_W     = 8,
    parameter int LVL_W      = 8,
    parameter int LVL_ZERO   = 16,
    parameter int LVL_HIGH   = 126,
    parameter int LEAD_CLKS  = 240,
    parameter int CLKS_60    = 1716,
    parameter int CLKS_50    = 1728,
    parameter int RATE_MUL   = 32,
    parameter int RUNIN_BITS = 7,
    localparam int PAY_W     = 2 * BYTE_W,
    localparam int NBITS     = RUNIN_BITS + cc_pkg::CC_FRAME_BITS + PAY_W,
    localparam int BIT_W     = $clog2(NBITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic [LINE_W-1:0] line_num,
    input  logic              field_odd,
    input  logic              mode_50hz,
    input  logic [TGT_W-1:0]  target_line,
    input  logic [PAY_W-1:0]  odd_payload,
    input  logic [PAY_W-1:0]  even_payload,
    output logic [LVL_W-1:0]  cc_level,
    output logic              cc_valid
);
    logic             start;
    logic             busy;
    logic             in_wave;
    logic [BIT_W-1:0] bit_idx;
    logic [1:0]       quarter;
    logic [PAY_W-1:0] payload_q;

    cc_field_select #(
        .LINE_W(LINE_W), .TGT_W(TGT_W), .PAY_W(PAY_W)
    ) u_sel (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_num(line_num),
        .target_line(target_line), .field_odd(field_odd),
        .odd_payload(odd_payload), .even_payload(even_payload),
        .busy(busy), .start(start), .payload_q(payload_q)
    );

    cc_bit_timer #(
        .LEAD_CLKS(LEAD_CLKS), .CLKS_60(CLKS_60), .CLKS_50(CLKS_50),
        .RATE_MUL(RATE_MUL), .NBITS(NBITS)
    ) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_50hz(mode_50hz),
        .busy(busy), .in_wave(in_wave), .bit_idx(bit_idx), .quarter(quarter)
    );

    cc_level_shaper #(
        .LVL_W(LVL_W), .LVL_ZERO(LVL_ZERO), .LVL_HIGH(LVL_HIGH),
        .RUNIN_BITS(RUNIN_BITS), .PAY_W(PAY_W), .BIT_W(BIT_W)
    ) u_shp (
        .in_wave(in_wave), .bit_idx(bit_idx), .quarter(quarter),
        .payload(payload_q), .level(cc_level), .valid(cc_valid)
    );
endmodule

// File: rtl/cc_line_inserter_chk.sv
// Checker for the caption line waveform inserter, attached by bind.
// Watches only the output pair and counts waveform length itself.
module cc_line_inserter_chk #(
    parameter int LVL_W    = 8,
    parameter int LVL_ZERO = 16,
    parameter int LVL_HIGH = 126,
    parameter int CLKS_60  = 1716,
    parameter int CLKS_50  = 1728,
    parameter int RATE_MUL = 32,
    parameter int NBITS    = 26
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LVL_W-1:0] cc_level,
    input logic             cc_valid
);
    localparam int N60   = (NBITS * CLKS_60 + RATE_MUL - 1) / RATE_MUL;
    localparam int N50   = (NBITS * CLKS_50 + RATE_MUL - 1) / RATE_MUL;
    localparam int RUN_W = $clog2(N50 + N60 + 2);
    localparam logic [LVL_W-1:0] L_ZERO = LVL_W'(LVL_ZERO);
    localparam logic [LVL_W-1:0] L_HIGH = LVL_W'(LVL_HIGH);
    localparam logic [LVL_W-1:0] L_MID  = LVL_W'((LVL_ZERO + LVL_HIGH) / 2);

    logic [RUN_W-1:0] run_len;

    // Length of the current run of valid cycles
    always_ff @(posedge clk) begin
        if (!rst_n)        run_len <= '0;
        else if (cc_valid) run_len <= run_len + 1'b1;
        else               run_len <= '0;
    end

    // R10
    blank_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cc_valid |-> cc_level == L_ZERO);

    // R5
    runin_start_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cc_valid) |-> cc_level == L_MID);

    // R7
    legal_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cc_valid |-> (cc_level == L_ZERO || cc_level == L_MID || cc_level == L_HIGH));

    // R3
    wave_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cc_valid) |-> (run_len == RUN_W'(N60) || run_len == RUN_W'(N50)));
endmodule

bind cc_line_inserter cc_line_inserter_chk #(
    .LVL_W(LVL_W), .LVL_ZERO(LVL_ZERO), .LVL_HIGH(LVL_HIGH),
    .CLKS_60(CLKS_60), .CLKS_50(CLKS_50), .RATE_MUL(RATE_MUL), .NBITS(NBITS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cc_level(cc_level), .cc_valid(cc_valid)
);

// File: tb/sim_cc_line_inserter.sv
// Directed bench for the caption line waveform inserter.
module sim_cc_line_inserter;
    localparam int CLK_PERIOD = 10;
    localparam int LEAD  = 240;
    localparam int L60   = 1716;
    localparam int L50   = 1728;
    localparam int CAP   = 1716;
    localparam int ZERO  = 16;
    localparam int HIGH  = 126;
    localparam int MID   = 71;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_start = 1'b0;
    logic [9:0]  line_num = '0;
    logic        field_odd = 1'b0;
    logic        mode_50hz = 1'b0;
    logic [4:0]  target_line = 5'd21;
    logic [15:0] odd_payload = '0;
    logic [15:0] even_payload = '0;
    logic [7:0]  cc_level;
    logic        cc_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic       cap_v [0:CAP];
    logic [7:0] cap_l [0:CAP];

    cc_line_inserter u0 (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_num(line_num),
        .field_odd(field_odd), .mode_50hz(mode_50hz), .target_line(target_line),
        .odd_payload(odd_payload), .even_payload(even_payload),
        .cc_level(cc_level), .cc_valid(cc_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input bit ok, input int got, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    // Expected {valid, level} after k edges past the matching line_start (R3 R4 R5 R6 R7)
    function automatic int exp_at(input int k, input bit hit, input logic [15:0] pay, input bit m50);
        int L, nw, c, b, q;
        L  = m50 ? L50 : L60;
        nw = (26 * L + 31) / 32;
        c  = k - LEAD;
        if (!hit || c < 0 || c >= nw) return ZERO;
        b = (c * 32) / L;
        q = (((c * 32) % L) * 4) / L;
        if (b < 7) return 256 + ((q == 1) ? HIGH : (q == 3) ? ZERO : MID);
        if (b < 9) return 256 + ZERO;
        if (b == 9) return 256 + HIGH;
        return 256 + (pay[b - 10] ? HIGH : ZERO);
    endfunction

    // poke: 0 none, 1 change payloads and mode, 2 repeat line_start
    task automatic run_line(input string tag, input int ln, input bit fodd, input bit m50,
                            input logic [15:0] opay, input logic [15:0] epay,
                            input bit hit, input logic [15:0] xpay, input int poke);
        int nv, nexp, e;
        int bad_k [0:3];
        int bad_g [0:3];
        int bad_e [0:3];
        for (int r = 0; r < 4; r++) bad_k[r] = -1;
        @(negedge clk);
        line_num = ln[9:0]; field_odd = fodd; mode_50hz = m50;
        odd_payload = opay; even_payload = epay; line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        for (int k = 1; k <= CAP; k++) begin
            @(negedge clk);
            cap_v[k] = cc_valid;
            cap_l[k] = cc_level;
            if (poke == 1 && k == LEAD + 600) begin
                odd_payload = ~opay; even_payload = ~epay; mode_50hz = ~m50;
            end
            if (poke == 2 && (k == 100 || k == LEAD + 300)) line_start = 1'b1;
            else line_start = 1'b0;
        end
        nv = 0;
        for (int k = 1; k <= CAP; k++) begin
            int reg_i, c, b, L;
            e = exp_at(k, hit, xpay, m50);
            if (cap_v[k]) nv++;
            L = m50 ? L50 : L60;
            c = k - LEAD;
            reg_i = 0;
            if (e >= 256) begin
                b = (c * 32) / L;
                reg_i = (b < 7) ? 1 : (b < 10) ? 2 : 3;
            end
            if (({23'd0, cap_v[k], cap_l[k]} != e) && bad_k[reg_i] < 0) begin
                bad_k[reg_i] = k;
                bad_g[reg_i] = {23'd0, cap_v[k], cap_l[k]};
                bad_e[reg_i] = e;
            end
        end
        nexp = hit ? ((26 * (m50 ? L50 : L60) + 31) / 32) : 0;
        check({tag, " R3 R4 valid cycle count"}, nv == nexp, nv, nexp);
        check({tag, " R10 level outside waveform (value=256*valid+level)"},
              bad_k[0] < 0, bad_g[0], bad_e[0]);
        if (hit) begin
            check({tag, " R5 run-in levels"}, bad_k[1] < 0, bad_g[1], bad_e[1]);
            check({tag, " R6 framing levels"}, bad_k[2] < 0, bad_g[2], bad_e[2]);
            check({tag, " R7 data levels"}, bad_k[3] < 0, bad_g[3], bad_e[3]);
        end
    endtask

    // R1: outputs after reset
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", cc_valid == 1'b0, cc_valid, 0);
        check("R1 level after reset", cc_level == 8'(ZERO), cc_level, ZERO);
    endtask

    // R2: wrong line, and target line without a strobe
    task automatic t_no_match();
        int seen;
        target_line = 5'd21;
        run_line("R2 wrong line", 22, 1'b1, 1'b0, 16'hFFFF, 16'hFFFF, 1'b0, 16'h0, 0);
        seen = 0;
        line_num = 10'd21;
        repeat (LEAD + 50) begin
            @(negedge clk);
            if (cc_valid) seen++;
        end
        check("R2 no strobe no waveform", seen == 0, seen, 0);
    endtask

    // R4 R5 R6 R7: odd field, 60 Hz, mixed payload
    task automatic t_odd60();
        target_line = 5'd21;
        run_line("R7 odd 60Hz", 21, 1'b1, 1'b0, 16'hA53C, 16'h1234, 1'b1, 16'hA53C, 0);
    endtask

    // R8: even field picks the even pair; other target line
    task automatic t_even60();
        target_line = 5'd15;
        run_line("R8 even field", 15, 1'b0, 1'b0, 16'h00FF, 16'h5AC3, 1'b1, 16'h5AC3, 0);
    endtask

    // R4: 50 Hz bit timing
    task automatic t_50hz();
        target_line = 5'd22;
        run_line("R4 50Hz", 22, 1'b1, 1'b1, 16'h8001, 16'h0, 1'b1, 16'h8001, 0);
    endtask

    // R7: extreme payloads
    task automatic t_extremes();
        target_line = 5'd21;
        run_line("R7 all ones", 21, 1'b0, 1'b0, 16'h0, 16'hFFFF, 1'b1, 16'hFFFF, 0);
        run_line("R7 all zeros", 21, 1'b1, 1'b1, 16'h0, 16'hFFFF, 1'b1, 16'h0, 0);
    endtask

    // R9: mid-line payload and mode change has no effect
    task automatic t_midline();
        run_line("R9 mid-line write", 21, 1'b1, 1'b0, 16'h6E91, 16'h0F0F, 1'b1, 16'h6E91, 1);
    endtask

    // R11: repeated strobe during lead-in and waveform is ignored
    task automatic t_retrigger();
        run_line("R11 repeat strobe", 21, 1'b0, 1'b1, 16'h3333, 16'hC71E, 1'b1, 16'hC71E, 2);
    endtask

    initial begin
        t_reset();
        t_no_match();
        t_odd60();
        t_even60();
        t_50hz();
        t_extremes();
        t_midline();
        t_retrigger();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule